// File: doc/BRIEF.md
# Packed-Byte Sum of Absolute Differences Unit

This execution unit takes two operand registers, each packing several unsigned byte elements, and reduces them to one scalar: the sum over all lanes of the magnitude of the difference between matching bytes. It serves block-matching and motion-search loops, where one pixel row of a candidate block is compared with a row of the reference block in a single operation.

Two lane modes are selected per operation by `in_wide`. In the narrow mode (`in_wide` = 0), only the four low byte lanes take part and the upper half of both operands is ignored. In the wide mode (`in_wide` = 1), all eight lanes take part. The work is split over two registered stages. The first stage forms the per-lane magnitudes. The second stage sums them through a balanced adder tree. It can also add the last delivered result, so that a search loop can chain row after row into one running total with no software addition.

Top module: `psad_unit`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it falls, `out_valid` is 0 and `out_sum` is 0.
- R2: `out_valid` is high in exactly the cycles that follow by two clock edges a cycle in which `in_valid` was sampled high.
- R3: In the wide mode (`in_wide` = 1), the result is the sum, over lanes 0 to 7, of |a_i − b_i|. Lane i occupies operand bits [8i+7:8i], and each byte is read as an unsigned value from 0 to 255.
- R4: In the narrow mode (`in_wide` = 0), only lanes 0 to 3 contribute, and bits 63:32 of both operands have no effect on the result.
- R5: Without accumulation, the result is exact and zero-extended into `out_sum`: at most 1020 in the narrow mode and at most 2040 in the wide mode, with no wrap.
- R6: With `in_accum` = 1, the result is the lane sum plus the most recent result delivered on `out_sum`, modulo 2^16. After reset, that earlier result is 0.
- R7: In a cycle with `out_valid` low, `out_sum` keeps its previous value.
- R8: One operation may be accepted every cycle. An accumulating operation issued in the cycle right after another one adds that one's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| in_wide | input | 1 | Lane mode: 1 = eight lanes, 0 = four low lanes |
| in_accum | input | 1 | Add the last delivered result to this one |
| op_a | input | 64 | First packed operand, lane i in bits [8i+7:8i] |
| op_b | input | 64 | Second packed operand, same layout |
| out_valid | output | 1 | `out_sum` carries a new result this cycle |
| out_sum | output | 16 | Scalar sum of absolute differences |

## Verification
The assertions assume that `in_valid` is low while reset is held. A lane-count bound on the result only holds if the operation it covers did not accumulate. The checker therefore looks back at `in_accum` and `in_wide` two cycles earlier. It also counts cycles since reset, so that no look-back reaches into the reset period. The bench drives every input on the falling edge, holds `in_valid` at 0 throughout reset, and applies accumulation only in the directed chaining and sequence tests. The table vectors all run without accumulation, so the range bound is exercised with the extreme byte patterns.

// File: rtl/psad_pkg.sv
package psad_pkg;

    // Lane mode picked per operation by the width select input.
    typedef enum logic {
        LANE_MODE_NARROW = 1'b0,
        LANE_MODE_WIDE   = 1'b1
    } lane_mode_e;

endpackage

// File: rtl/psad_lane_absdiff.sv
// One byte lane: unsigned magnitude of the difference, registered (stage 1).
module psad_lane_absdiff #(
    parameter int ELEM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              keep,
    input  logic [ELEM_W-1:0] elem_a,
    input  logic [ELEM_W-1:0] elem_b,
    output logic [ELEM_W-1:0] dist_q
);

    logic [ELEM_W:0]   delta;
    logic [ELEM_W-1:0] mag;

    // Widen by one bit so the borrow shows the sign, then negate when set.
    always_comb begin
        delta = {1'b0, elem_a} - {1'b0, elem_b};
        mag   = delta[ELEM_W] ? (ELEM_W'(0) - delta[ELEM_W-1:0])
                              : delta[ELEM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dist_q <= '0;
        end else if (load) begin
            dist_q <= keep ? mag : '0;
        end
    end

endmodule

// File: rtl/psad_reduce.sv
// Balanced adder tree over LEAVES byte magnitudes (LEAVES a power of two).
module psad_reduce #(
    parameter int LEAVES = 8,
    parameter int ELEM_W = 8,
    parameter int SUM_W  = ELEM_W + $clog2(LEAVES)
) (
    input  logic [LEAVES*ELEM_W-1:0] leaf_flat,
    output logic [SUM_W-1:0]         total
);

    localparam int LEVELS = $clog2(LEAVES);

    generate
        for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
            localparam int WIDTH_AT = LEAVES >> l;
            logic [SUM_W-1:0] v [WIDTH_AT];
            for (genvar k = 0; k < WIDTH_AT; k++) begin : g_node
                if (l == 0) begin : g_leaf
                    assign v[k] = SUM_W'(leaf_flat[k*ELEM_W +: ELEM_W]);
                end else begin : g_add
                    assign v[k] = g_lvl[l-1].v[2*k] + g_lvl[l-1].v[2*k+1];
                end
            end
        end
    endgenerate

    assign total = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/psad_unit.sv
// Packed-byte sum of absolute differences, two pipeline stages.
module psad_unit
    import psad_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ELEM_W = 8,
    parameter int RES_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_wide,
    input  logic                    in_accum,
    input  logic [LANES*ELEM_W-1:0] op_a,
    input  logic [LANES*ELEM_W-1:0] op_b,
    output logic                    out_valid,
    output logic [RES_W-1:0]        out_sum
);

    localparam int DATA_W       = LANES * ELEM_W;
    localparam int SUM_W        = ELEM_W + $clog2(LANES);
    localparam int NARROW_LANES = LANES / 2;

    lane_mode_e        mode;
    logic              s1_valid;
    logic              s1_accum;
    logic [DATA_W-1:0] dist_flat;
    logic [SUM_W-1:0]  tree_sum;
    logic [RES_W-1:0]  base;
    logic [RES_W-1:0]  next_sum;

    assign mode = lane_mode_e'(in_wide);

    // Stage 1: per-lane magnitudes, upper lanes zeroed in the narrow mode.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam bit LOWER_HALF = (i < NARROW_LANES);
            logic keep_lane;
            assign keep_lane = LOWER_HALF || (mode == LANE_MODE_WIDE);
            psad_lane_absdiff #(.ELEM_W(ELEM_W)) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (in_valid),
                .keep   (keep_lane),
                .elem_a (op_a[i*ELEM_W +: ELEM_W]),
                .elem_b (op_b[i*ELEM_W +: ELEM_W]),
                .dist_q (dist_flat[i*ELEM_W +: ELEM_W])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_accum <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_accum <= in_valid && in_accum;
        end
    end

    // Stage 2: reduction tree plus optional running total.
    psad_reduce #(.LEAVES(LANES), .ELEM_W(ELEM_W), .SUM_W(SUM_W)) u_tree (
        .leaf_flat (dist_flat),
        .total     (tree_sum)
    );

    always_comb begin
        base     = s1_accum ? out_sum : '0;
        next_sum = base + RES_W'(tree_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_sum <= next_sum;
            end
        end
    end

endmodule

// File: rtl/psad_unit_chk.sv
module psad_unit_chk #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 8,
    parameter int RES_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_wide,
    input logic             in_accum,
    input logic             out_valid,
    input logic [RES_W-1:0] out_sum
);

    localparam int MAX_WIDE   = LANES * ((1 << ELEM_W) - 1);
    localparam int MAX_NARROW = (LANES / 2) * ((1 << ELEM_W) - 1);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sum == '0));

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && out_valid && !$past(in_accum, 2))
        |-> (32'(out_sum) <= ($past(in_wide, 2) ? MAX_WIDE : MAX_NARROW)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && !out_valid) |-> $stable(out_sum));

endmodule

bind psad_unit psad_unit_chk #(.LANES(LANES), .ELEM_W(ELEM_W), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_wide   (in_wide),
    .in_accum  (in_accum),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/psad_unit_test.sv
module psad_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_wide = 1'b0;
    logic        in_accum = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [15:0] out_sum;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    psad_unit uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_wide (in_wide),
        .in_accum (in_accum), .op_a (op_a), .op_b (op_b),
        .out_valid (out_valid), .out_sum (out_sum)
    );

    // {wide, a, b, expected}
    localparam int NVEC = 11;
    localparam logic [144:0] VEC [NVEC] = '{
        {1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 16'd0},    // R3 zero
        {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 16'd2040}, // R5 wide max
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 16'd1020}, // R5 narrow max
        {1'b0, 64'hAAAA_BBBB_0000_0000, 64'h1234_5678_0000_0000, 16'd0},    // R4 upper ignored
        {1'b1, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 16'd32},   // R3 mixed sign
        {1'b0, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 16'd16},   // R4 low lanes
        {1'b1, 64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, 16'd2040}, // R5 alternating
        {1'b1, 64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 16'd8},    // R3 unsigned read
        {1'b0, 64'h0000_0000_1020_3040, 64'h0000_0000_4030_2010, 16'd128},  // R4
        {1'b1, 64'h0000_0000_0000_0064, 64'h0000_0000_0000_00C8, 16'd100},  // R3 single lane
        {1'b0, 64'h0000_0000_01FF_FE00, 64'h0000_0000_FF01_00FE, 16'd1016}  // R4 near max
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one operation and check its result two edges later.
    task automatic issue(string req, bit wide, bit acc, logic [63:0] a,
                         logic [63:0] b, logic [15:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_wide = wide; in_accum = acc; op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0; in_accum = 1'b0;
        check("R2 no early valid", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R2 valid after two edges", 32'(out_valid), 32'd1);
        check(req, 32'(out_sum), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset sum", 32'(out_sum), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][144] ? "R3/R5 wide vector" : "R4/R5 narrow vector",
                  VEC[i][144], 1'b0, VEC[i][143:80], VEC[i][79:16], VEC[i][15:0]);
        end

        // R6: accumulation sequence across both modes
        issue("R6 base", 1'b1, 1'b0, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 16'd32);
        issue("R6 accumulate wide", 1'b1, 1'b1, 64'h64, 64'hC8, 16'd132);
        issue("R6 accumulate narrow", 1'b0, 1'b1, 64'hFFFF_FFFF_0506_0708,
              64'h0000_0000_0403_0201, 16'd148);

        // R7: idle cycles keep the result
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7 idle valid", 32'(out_valid), 32'd0);
            check("R7 idle hold", 32'(out_sum), 32'd148);
        end

        // R8: back-to-back chained operations, wrapping modulo 2^16 (R6)
        for (int c = 0; c < 35; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check("R8 chained valid", 32'(out_valid), 32'd1);
                check(c == 34 ? "R6 wrap" : "R8 chained sum", 32'(out_sum),
                      ((c - 1) * 2040) % 65536);
            end
            if (c < 33) begin
                in_valid = 1'b1; in_wide = 1'b1; in_accum = (c != 0);
                op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h0;
            end else begin
                in_valid = 1'b0; in_accum = 1'b0;
            end
        end
        @(negedge clk);
        check("R2 valid drops", 32'(out_valid), 32'd0);

        // R1: reset clears the running total; R6 then starts from zero
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset sum", 32'(out_sum), 32'd0);
        check("R1 mid-run reset valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        issue("R6 accumulate after reset", 1'b1, 1'b1, 64'h0102_0304_0506_0708,
              64'h0807_0605_0403_0201, 16'd32);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule